// File: doc/BRIEF.md
# Fractional Pulse-Selecting Clock Divider

This block turns a fast reference clock into a train of single-cycle enable pulses whose long-run rate is a fixed rational fraction NUM/DEN of the reference. With the default NUM = 40 and DEN = 107, a 10.7 MHz reference yields an average of 4 MHz. A phase accumulator adds NUM every enabled cycle, modulo DEN, and selects the cycle on which it wraps. The wraps spread the short (two-cycle) and long (three-cycle) pulse spacings evenly through the frame, so they are never grouped.

A frame counter marks each run of DEN enabled cycles with a strobe. The strobe coincides with the last pulse of the frame, so any gate built from whole frames is exact to the reference edge. An optional toggle stage gives a squared-up output at half the pulse rate. Logic downstream uses the pulse as a clock enable, never as a clock.

Top module: `frac_pulse_div`

## Requirements
- R1: `pulse_o` is high for one cycle at a time and only in a cycle where `en_i` is high.
- R2: Every frame of DEN enabled cycles holds exactly NUM pulses (40 of 107 by default).
- R3: Between two successive pulses there are either floor(DEN/NUM) or ceil(DEN/NUM) enabled cycles (2 or 3 by default). Disabled cycles are not counted.
- R4: `frame_o` is high in the last enabled cycle of each frame, which is the same cycle as that frame's NUM-th pulse. It is high in no other cycle.
- R5: After reset is released, the first `frame_o` falls on the DEN-th enabled cycle.
- R6: While `en_i` is low, `pulse_o` and `frame_o` stay low and the divider phase is held. When `en_i` returns high, the pulse pattern resumes exactly where it left off.
- R7: With SQUARE_EN = 1, `square_o` inverts on the clock edge that ends each pulse cycle and holds otherwise. With SQUARE_EN = 0 it is constant 0.
- R8: A synchronous active-low reset (`rst_ni` = 0 at a clock edge) clears the phase, the frame position and `square_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Advance enable; when low, the phase and frame position hold |
| pulse_o | output | 1 | Selected-cycle pulse, NUM out of every DEN enabled cycles |
| square_o | output | 1 | Toggled half-rate output (0 when SQUARE_EN = 0) |
| frame_o | output | 1 | Frame boundary strobe, on the last pulse of each frame |

## Verification
The bench builds the block with its defaults: NUM = 40, DEN = 107, SQUARE_EN = 1. These are the values that give the mixed 2/3 spacing and a frame wrap that lands on a pulse. Long runs with `en_i` held high cover many whole frames and the first-strobe timing after reset. Randomly gated enable, with stretches of several idle cycles, tests that the phase is held, and a reset in the middle of a frame tests the restart. At every cycle the outputs are compared against an accumulator model written from the requirements. Per-frame pulse counts and spacing are also tallied from the observed pulses alone.

// File: rtl/fdiv_pkg.sv
// Package: shared helpers for the fractional pulse divider.
// Assumes: called only with positive integer arguments at elaboration.
package fdiv_pkg;

    // Width needed to hold values 0 .. n-1 (at least 1 bit).
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fdiv_phase_acc.sv
// Module: phase accumulator that selects NUM cycles out of every DEN enabled cycles.
// On each enabled cycle it adds NUM modulo DEN; the cycle on which the sum
// reaches DEN is selected. Assumes 0 < NUM < DEN.
module fdiv_phase_acc #(
    parameter int unsigned NUM = 40,
    parameter int unsigned DEN = 107
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic sel_o
);
    import fdiv_pkg::*;

    localparam int unsigned AW = idx_w(DEN) + 1;
    localparam logic [AW-1:0] STEP   = AW'(NUM);
    localparam logic [AW-1:0] MODULO = AW'(DEN);
    localparam logic [AW-1:0] THRESH = AW'(DEN - NUM);

    logic [AW-1:0] acc_q;
    logic          wrap;

    // Wrap detection: the next addition would reach the modulus.
    always_comb begin
        wrap  = (acc_q >= THRESH);
        sel_o = en_i && wrap;
    end

    // Phase update: add the step modulo DEN when enabled, hold otherwise.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q <= '0;
        end else if (en_i) begin
            if (wrap) acc_q <= acc_q + STEP - MODULO;
            else      acc_q <= acc_q + STEP;
        end
    end

    assert_acc_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_q < MODULO);
    assert_hold_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(acc_q));
    assert_single_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_o |=> !sel_o);
    assert_reset_clears_R8: assert property (@(posedge clk_i)
        !rst_ni |=> acc_q == '0);

endmodule

// File: rtl/fdiv_frame_ctr.sv
// Module: counts enabled cycles modulo DEN and flags the last cycle of a frame.
// Assumes DEN >= 2. The count holds while the enable is low.
module fdiv_frame_ctr #(
    parameter int unsigned DEN = 107
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic last_o
);
    import fdiv_pkg::*;

    localparam int unsigned CW = idx_w(DEN);
    localparam logic [CW-1:0] LAST = CW'(DEN - 1);

    logic [CW-1:0] cnt_q;

    // Last-cycle flag for the current frame position.
    always_comb last_o = (cnt_q == LAST);

    // Frame position: advance on enable, wrap to zero after the last cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (en_i)    cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end

    assert_cnt_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
    assert_frame_wraps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && last_o) |=> cnt_q == '0);
    assert_frame_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(cnt_q));

endmodule

// File: rtl/fdiv_square.sv
// Module: toggle stage giving a squared-up output at half the pulse rate.
// Assumes its input is a single-cycle pulse in the same clock domain.
module fdiv_square (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pulse_i,
    output logic sq_o
);
    logic sq_q;

    // Toggle register: invert on each pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      sq_q <= 1'b0;
        else if (pulse_i) sq_q <= ~sq_q;
    end

    // Output drive.
    always_comb sq_o = sq_q;

    assert_toggle_on_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_i |=> sq_o != $past(sq_o));
    assert_hold_no_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pulse_i |=> $stable(sq_o));

endmodule

// File: rtl/frac_pulse_div.sv
// Module: fractional pulse-selecting divider (top).
// Selects NUM of every DEN enabled reference cycles, spread evenly by a phase
// accumulator. It flags each DEN-cycle frame on its final pulse and can add
// a half-rate square output. Assumes 0 < NUM < DEN and that DEN is a
// multiple of the accumulator period, so each frame ends on a pulse
// (true for 40/107).
module frac_pulse_div #(
    parameter int unsigned NUM       = 40,
    parameter int unsigned DEN       = 107,
    parameter bit          SQUARE_EN = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic pulse_o,
    output logic square_o,
    output logic frame_o
);
    logic sel;
    logic last;

    fdiv_phase_acc #(.NUM(NUM), .DEN(DEN)) u_acc (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .sel_o (sel)
    );

    fdiv_frame_ctr #(.DEN(DEN)) u_frame (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .last_o(last)
    );

    // Output selection: the pulse and the frame strobe on the frame's final cycle.
    always_comb begin
        pulse_o = sel;
        frame_o = en_i && last;
    end

    generate
        if (SQUARE_EN) begin : g_square
            fdiv_square u_sq (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .pulse_i(sel),
                .sq_o   (square_o)
            );
        end else begin : g_no_square
            assign square_o = 1'b0;
        end
    endgenerate

    assert_frame_on_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |-> pulse_o);
    assert_pulse_needs_en_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> en_i);

endmodule

// File: tb/frac_pulse_div_tb.sv
module frac_pulse_div_tb;
    localparam int unsigned NUM = 40;
    localparam int unsigned DEN = 107;
    localparam int unsigned GMIN = DEN / NUM;
    localparam int unsigned GMAX = (DEN + NUM - 1) / NUM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic pulse, square, frame;

    int errors = 0;
    int checks = 0;

    // Reference model state.
    int m_acc = 0;
    int m_pos = 0;
    bit m_sq = 1'b0;
    // Observation-based tallies.
    int obs_in_frame = 0;
    int gap = 0;
    bit seen_pulse = 1'b0;
    int since_reset = 0;
    bit first_frame_seen = 1'b0;

    frac_pulse_div #(.NUM(NUM), .DEN(DEN), .SQUARE_EN(1'b1)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en),
        .pulse_o(pulse), .square_o(square), .frame_o(frame)
    );

    always #5 clk = ~clk;

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic bit exp_pulse(input bit e, input int acc);
        return e && (acc + NUM >= DEN);
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic model_reset();
        m_acc = 0; m_pos = 0; m_sq = 1'b0;
        obs_in_frame = 0; gap = 0; seen_pulse = 1'b0;
        since_reset = 0; first_frame_seen = 1'b0;
    endtask

    // One cycle: drive en at the negedge, check the outputs, then advance the model.
    task automatic step(input bit e);
        bit ep, ef;
        en = e;
        #1;
        ep = exp_pulse(e, m_acc);
        ef = e && (m_pos == DEN - 1);
        chk("R1/R6 pulse", pulse, ep);
        chk("R4 frame", frame, ef);
        chk("R7 square", square, m_sq);
        if (e) begin
            since_reset++;
            gap++;
            if (pulse) begin
                if (seen_pulse) begin
                    checks++;
                    if (gap < GMIN || gap > GMAX) begin
                        errors++;
                        $display("FAIL R3 gap: actual=%0d expected=%0d..%0d", gap, GMIN, GMAX);
                    end
                end
                seen_pulse = 1'b1;
                gap = 0;
                obs_in_frame++;
            end
            if (frame) begin
                chk("R2 pulses per frame", obs_in_frame, NUM);
                if (!first_frame_seen) chk("R5 first frame cycle", since_reset, DEN);
                first_frame_seen = 1'b1;
                obs_in_frame = 0;
            end
            if (ep) m_sq = ~m_sq;
            m_acc = (m_acc + NUM) % DEN;
            m_pos = (m_pos + 1) % DEN;
        end else begin
            chk("R6 idle no pulse", pulse, 0);
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        en = 1'b0;
        repeat (n) @(negedge clk);
        #1;
        chk("R8 reset pulse", pulse, 0);
        chk("R8 reset square", square, 0);
        chk("R8 reset frame", frame, 0);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset(3);
        // Directed: continuous enable over several frames (R2, R3, R4, R5).
        for (int i = 0; i < 5 * DEN; i++) step(1'b1);
        // Directed: long idle stretch holds the phase (R6).
        for (int i = 0; i < 20; i++) step(1'b0);
        for (int i = 0; i < 2 * DEN; i++) step(1'b1);
        // Random gated enable (R6, R1, R7).
        for (int i = 0; i < 20000; i++) step(($urandom % 10) < 7);
        // Reset mid-frame, then check restart timing (R8, R5).
        for (int i = 0; i < 50; i++) step(1'b1);
        do_reset(2);
        for (int i = 0; i < 3 * DEN; i++) step(1'b1);
        // Random idle bursts.
        for (int i = 0; i < 4000; i++) step(($urandom % 4) != 0);
        chk("R5 frame seen after reset", first_frame_seen, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule